// File: doc/BRIEF.md
# LIN Slave Header Receiver

This block takes in the header that opens every LIN frame while the node acts as a slave. It watches one serial receive line. It ignores all traffic until it sees a break, which is a long stretch of the line held at the dominant (low) level. After the break it waits for the recessive delimiter. It then receives the sync character and checks it against 0x55. Finally it captures the protected-identifier character into an output register.

Sticky status flags record five events: a break was seen, an identifier arrived, the header ran past its time budget, the sync character was wrong, and a stop bit was missing. One strobe clears all five flags together. A baud generator outside the block supplies a sampling tick at `OVS` times the bit rate. Every bit time lasts exactly `OVS` ticks, and the block samples each bit in the middle of that time. Identifier parity, the response and checksum phases, and master transmission belong to other blocks.

Top module: `lin_hdr_rx`

## Requirements
- R1: After reset, all five flags are low and `rx_id` is 0x00.
- R2: `brk_seen` is set once `rxd` has been low on `BRK_BITS`×`OVS` consecutive ticks (11 bit times by default). A low run of 10 bit times does not set it.
- R3: Before a break is detected, the block ignores any character on the line. Neither `rx_id` nor `id_rcvd` changes.
- R4: If the first character after the break delimiter has a valid stop bit and a value other than 0x55, `sync_err` is set. The block then waits for a new break, so a following character does not set `id_rcvd`.
- R5: Characters are framed as one low start bit, eight data bits sent least significant bit first, and one high stop bit. The character after a valid sync is loaded into `rx_id`, and `id_rcvd` is set.
- R6: If the identifier has not arrived `HDR_BITS` bit times (48 by default) after the first low tick of the break, `hdr_tmo` is set and the block waits for a new break. Before that time, `hdr_tmo` stays low.
- R7: A low stop bit on the sync or identifier character sets `frm_err` and returns the block to waiting for a break. The next complete header is then received normally.
- R8: A one-cycle pulse on `rst_sts` clears all five flags and leaves `rx_id` unchanged. If a flag is set in the same cycle as the strobe, the set wins.
- R9: A new break that arrives partway through a header restarts reception, including the header timer. A header that follows the new break is accepted even when the total time since the first break is longer than the timeout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 1 | Receive line (low = dominant) |
| os_tick | input | 1 | One-cycle sampling pulse, OVS per bit time |
| rst_sts | input | 1 | Strobe that clears all status flags |
| rx_id | output | 8 | Last identifier character captured |
| brk_seen | output | 1 | Sticky: break detected |
| id_rcvd | output | 1 | Sticky: identifier received |
| hdr_tmo | output | 1 | Sticky: header exceeded its maximum time |
| sync_err | output | 1 | Sticky: sync character was not 0x55 |
| frm_err | output | 1 | Sticky: stop bit missing on sync or identifier |

## Verification
The assertions assume the following about the inputs:
- `os_tick` is a single-cycle pulse with a fixed period.
- `rxd` changes only on bit-time boundaries that line up with whole groups of `OVS` ticks.
- `rst_sts` is a one-cycle strobe.

The bench meets these assumptions in three ways. It generates the tick from a free-running divider. It drives `rxd` at falling clock edges and holds each value for a whole number of bit times. It pulses `rst_sts` for exactly one cycle. The random headers vary the break length (both below and above the threshold), the delimiter length, the gap between characters, the sync value and the stop bits. Every header stays well under the 48-bit budget, so in the random part only the directed cases exercise timeouts.

// File: rtl/lin_hdr_pkg.sv
package lin_hdr_pkg;

    typedef enum logic [1:0] {
        HS_IDLE,
        HS_DELIM,
        HS_SYNC,
        HS_PID
    } hdr_state_t;

    typedef enum logic [1:0] {
        CS_HUNT,
        CS_START,
        CS_DATA,
        CS_STOP
    } chr_state_t;

    typedef struct packed {
        logic [7:0] data;
        logic       stop_ok;
    } chr_res_t;

    localparam logic [7:0] SYNC_BYTE = 8'h55;

    function automatic logic sync_ok(input logic [7:0] b);
        return b == SYNC_BYTE;
    endfunction

endpackage

// File: rtl/lin_brk_det.sv
module lin_brk_det #(
    parameter int RUN_TICKS = 88
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic rxd,
    output logic brk_pulse
);
    localparam int W = $clog2(RUN_TICKS + 1);
    localparam logic [W-1:0] RUN_MAX = W'(RUN_TICKS);
    localparam logic [W-1:0] RUN_PRE = W'(RUN_TICKS - 1);

    logic [W-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt   <= '0;
            brk_pulse <= 1'b0;
        end else begin
            brk_pulse <= 1'b0;
            if (tick) begin
                if (rxd) begin
                    low_cnt <= '0;
                end else if (low_cnt != RUN_MAX) begin
                    low_cnt <= low_cnt + 1'b1;
                    if (low_cnt == RUN_PRE)
                        brk_pulse <= 1'b1;
                end
            end
        end
    end

    AST_BRK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        brk_pulse |=> !brk_pulse); // R2

endmodule

// File: rtl/lin_char_rx.sv
module lin_char_rx
    import lin_hdr_pkg::*;
#(
    parameter int OVS = 8,
    parameter int DW  = 8
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     en,
    input  logic     tick,
    input  logic     rxd,
    output logic     done,
    output chr_res_t res
);
    localparam int CW = $clog2(OVS);
    localparam int IW = $clog2(DW);
    localparam logic [CW-1:0] HALF_M1 = CW'(OVS / 2 - 1);
    localparam logic [CW-1:0] LAST    = CW'(OVS - 1);
    localparam logic [IW-1:0] IDX_END = IW'(DW - 1);

    chr_state_t     st;
    logic [CW-1:0]  cnt;
    logic [IW-1:0]  idx;
    logic [DW-1:0]  shreg;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            st    <= CS_HUNT;
            cnt   <= '0;
            idx   <= '0;
            shreg <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                unique case (st)
                    CS_HUNT: begin
                        if (!rxd) begin
                            st  <= CS_START;
                            cnt <= '0;
                        end
                    end
                    CS_START: begin
                        if (cnt == HALF_M1) begin
                            cnt <= '0;
                            idx <= '0;
                            st  <= rxd ? CS_HUNT : CS_DATA;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    CS_DATA: begin
                        if (cnt == LAST) begin
                            cnt   <= '0;
                            shreg <= {rxd, shreg[DW-1:1]};
                            if (idx == IDX_END)
                                st <= CS_STOP;
                            else
                                idx <= idx + 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    CS_STOP: begin
                        if (cnt == LAST) begin
                            done <= 1'b1;
                            st   <= CS_HUNT;
                            cnt  <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res <= '0;
        end else if (en && tick && st == CS_STOP && cnt == LAST) begin
            res.data    <= shreg;
            res.stop_ok <= rxd;
        end
    end

    AST_DONE_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(en)); // R3

endmodule

// File: rtl/lin_hdr_timer.sv
module lin_hdr_timer #(
    parameter int START_TICKS = 88,
    parameter int LIMIT_TICKS = 384
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic load,
    input  logic run,
    output logic expired
);
    localparam int W = $clog2(LIMIT_TICKS + 1);
    localparam logic [W-1:0] START_V = W'(START_TICKS);
    localparam logic [W-1:0] LIMIT_V = W'(LIMIT_TICKS);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= START_V;
        else if (run && tick && cnt != LIMIT_V)
            cnt <= cnt + 1'b1;
    end

    assign expired = run && (cnt == LIMIT_V);

endmodule

// File: rtl/lin_hdr_rx.sv
module lin_hdr_rx
    import lin_hdr_pkg::*;
#(
    parameter int OVS      = 8,
    parameter int BRK_BITS = 11,
    parameter int HDR_BITS = 48
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rxd,
    input  logic       os_tick,
    input  logic       rst_sts,
    output logic [7:0] rx_id,
    output logic       brk_seen,
    output logic       id_rcvd,
    output logic       hdr_tmo,
    output logic       sync_err,
    output logic       frm_err
);
    localparam int BRK_TICKS = BRK_BITS * OVS;
    localparam int HDR_TICKS = HDR_BITS * OVS;

    hdr_state_t state;
    logic       brk_pulse;
    logic       expired;
    logic       chr_en;
    logic       chr_done;
    chr_res_t   chr;

    assign chr_en = (state == HS_SYNC) || (state == HS_PID);

    lin_brk_det #(.RUN_TICKS(BRK_TICKS)) u_brk (
        .clk       (clk),
        .rst       (rst),
        .tick      (os_tick),
        .rxd       (rxd),
        .brk_pulse (brk_pulse)
    );

    lin_char_rx #(.OVS(OVS), .DW(8)) u_chr (
        .clk  (clk),
        .rst  (rst),
        .en   (chr_en),
        .tick (os_tick),
        .rxd  (rxd),
        .done (chr_done),
        .res  (chr)
    );

    lin_hdr_timer #(.START_TICKS(BRK_TICKS), .LIMIT_TICKS(HDR_TICKS)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .tick    (os_tick),
        .load    (brk_pulse),
        .run     (state != HS_IDLE),
        .expired (expired)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= HS_IDLE;
            rx_id    <= '0;
            brk_seen <= 1'b0;
            id_rcvd  <= 1'b0;
            hdr_tmo  <= 1'b0;
            sync_err <= 1'b0;
            frm_err  <= 1'b0;
        end else begin
            if (rst_sts) begin
                brk_seen <= 1'b0;
                id_rcvd  <= 1'b0;
                hdr_tmo  <= 1'b0;
                sync_err <= 1'b0;
                frm_err  <= 1'b0;
            end
            if (brk_pulse) begin
                brk_seen <= 1'b1;
                state    <= HS_DELIM;
            end else if (expired) begin
                hdr_tmo <= 1'b1;
                state   <= HS_IDLE;
            end else begin
                unique case (state)
                    HS_IDLE: ;
                    HS_DELIM: begin
                        if (os_tick && rxd)
                            state <= HS_SYNC;
                    end
                    HS_SYNC: begin
                        if (chr_done) begin
                            if (!chr.stop_ok) begin
                                frm_err <= 1'b1;
                                state   <= HS_IDLE;
                            end else if (!sync_ok(chr.data)) begin
                                sync_err <= 1'b1;
                                state    <= HS_IDLE;
                            end else begin
                                state <= HS_PID;
                            end
                        end
                    end
                    HS_PID: begin
                        if (chr_done) begin
                            if (!chr.stop_ok) begin
                                frm_err <= 1'b1;
                            end else begin
                                rx_id   <= chr.data;
                                id_rcvd <= 1'b1;
                            end
                            state <= HS_IDLE;
                        end
                    end
                endcase
            end
        end
    end

    AST_BRK_AFTER_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(brk_seen) |-> !$past(rxd)); // R2
    AST_DEAF_IDLE: assert property (@(posedge clk) disable iff (rst)
        (state == HS_IDLE) |=> !$rose(id_rcvd)); // R3
    AST_SYNC_ERR_BYTE: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_err) |-> (chr.data != SYNC_BYTE)); // R4
    AST_ID_MATCH: assert property (@(posedge clk) disable iff (rst)
        $rose(id_rcvd) |-> (rx_id == chr.data)); // R5
    AST_TMO_IDLE: assert property (@(posedge clk) disable iff (rst)
        $rose(hdr_tmo) |-> (state == HS_IDLE)); // R6
    AST_FRM_IDLE: assert property (@(posedge clk) disable iff (rst)
        $rose(frm_err) |-> (state == HS_IDLE)); // R7
    AST_CLR_BRK: assert property (@(posedge clk) disable iff (rst)
        (rst_sts && !brk_pulse) |=> !brk_seen); // R8
    AST_RESTART: assert property (@(posedge clk) disable iff (rst)
        brk_pulse |=> (state == HS_DELIM)); // R9

endmodule

// File: tb/lin_hdr_rx_test.sv
module lin_hdr_rx_test;
    localparam int OVS  = 8;
    localparam int TDIV = 4;
    localparam int BITC = OVS * TDIV;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rxd = 1'b1;
    logic       os_tick;
    logic       rst_sts = 1'b0;
    logic [7:0] rx_id;
    logic       brk_seen, id_rcvd, hdr_tmo, sync_err, frm_err;
    logic [1:0] div = 2'd0;

    int n_chk  = 0;
    int n_fail = 0;
    logic [7:0] last_id = 8'h00;

    always #10 clk = ~clk;
    always @(posedge clk) div <= div + 2'd1;
    assign os_tick = (div == 2'd0);

    lin_hdr_rx #(.OVS(OVS), .BRK_BITS(11), .HDR_BITS(48)) uut (
        .clk(clk), .rst(rst), .rxd(rxd), .os_tick(os_tick), .rst_sts(rst_sts),
        .rx_id(rx_id), .brk_seen(brk_seen), .id_rcvd(id_rcvd), .hdr_tmo(hdr_tmo),
        .sync_err(sync_err), .frm_err(frm_err)
    );

    typedef struct packed {
        logic       brk;
        logic       id;
        logic       serr;
        logic       ferr;
        logic [7:0] idv;
    } exp_t;

    function automatic exp_t predict(input int brk, input logic [7:0] sy,
                                     input logic sstop, input logic [7:0] id,
                                     input logic istop);
        exp_t e = '0;
        if (brk < 11) return e;
        e.brk = 1'b1;
        if (!sstop) e.ferr = 1'b1;
        else if (sy != 8'h55) e.serr = 1'b1;
        else if (!istop) e.ferr = 1'b1;
        else begin
            e.id  = 1'b1;
            e.idv = id;
        end
        return e;
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic hold(input logic v, input int bits);
        rxd = v;
        repeat (bits * BITC) @(negedge clk);
    endtask

    task automatic send_char(input logic [7:0] b, input logic stop_ok);
        hold(1'b0, 1);
        for (int i = 0; i < 8; i++) hold(b[i], 1);
        hold(stop_ok, 1);
        rxd = 1'b1;
    endtask

    task automatic header(input int brk, input int delim, input logic [7:0] sy,
                          input logic sstop, input int gap, input logic [7:0] id,
                          input logic istop);
        hold(1'b0, brk);
        hold(1'b1, delim);
        send_char(sy, sstop);
        hold(1'b1, gap);
        send_char(id, istop);
        hold(1'b1, 3);
    endtask

    task automatic clear_sts();
        @(negedge clk) rst_sts = 1'b1;
        @(negedge clk) rst_sts = 1'b0;
    endtask

    task automatic chk_flags(input string req, input exp_t e, input logic tmo);
        chk({req, " brk_seen"}, brk_seen, e.brk);
        chk({req, " id_rcvd"},  id_rcvd,  e.id);
        chk({req, " sync_err"}, sync_err, e.serr);
        chk({req, " frm_err"},  frm_err,  e.ferr);
        chk({req, " hdr_tmo"},  hdr_tmo,  tmo);
        if (e.id) last_id = e.idv;
        chk({req, " rx_id"}, rx_id, last_id);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        exp_t e;
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk_flags("R1 reset", '0, 1'b0);

        // R2 R3: 10-bit low run is not a break; the following characters are ignored
        header(10, 1, 8'h55, 1'b1, 0, 8'h3C, 1'b1);
        chk_flags("R2 R3 short break", predict(10, 8'h55, 1, 8'h3C, 1), 1'b0);

        // R2 R5: exactly 11 bits of break, identifier captured LSB first
        header(11, 1, 8'h55, 1'b1, 0, 8'hA1, 1'b1);
        chk_flags("R2 R5 min break", predict(11, 8'h55, 1, 8'hA1, 1), 1'b0);

        // R8: strobe clears flags, rx_id is kept
        clear_sts();
        chk_flags("R8 clear", '0, 1'b0);

        // R4: wrong sync value
        header(13, 1, 8'h54, 1'b1, 0, 8'h77, 1'b1);
        chk_flags("R4 bad sync", predict(13, 8'h54, 1, 8'h77, 1), 1'b0);
        clear_sts();

        // R7: missing stop bit on sync, then a complete header is accepted
        header(13, 1, 8'h55, 1'b0, 1, 8'h5A, 1'b1);
        chk_flags("R7 sync stop", predict(13, 8'h55, 0, 8'h5A, 1), 1'b0);
        header(12, 2, 8'h55, 1'b1, 1, 8'h5A, 1'b1);
        e = predict(12, 8'h55, 1, 8'h5A, 1);
        e.ferr = 1'b1;
        chk_flags("R7 recover", e, 1'b0);
        clear_sts();

        // R6: sync then silence; no timeout at 47.5 bits, timeout at 48.5 bits
        hold(1'b0, 13);
        hold(1'b1, 1);
        send_char(8'h55, 1'b1);
        hold(1'b1, 23);
        repeat (BITC / 2) @(negedge clk);
        e = '0;
        e.brk = 1'b1;
        chk_flags("R6 before limit", e, 1'b0);
        repeat (BITC) @(negedge clk);
        chk_flags("R6 after limit", e, 1'b1);
        clear_sts();
        chk_flags("R8 clear tmo", '0, 1'b0);

        // R9: second break after sync restarts the header and its timer
        hold(1'b0, 13);
        hold(1'b1, 1);
        send_char(8'h55, 1'b1);
        header(13, 1, 8'h55, 1'b1, 0, 8'hC3, 1'b1);
        e = predict(13, 8'h55, 1, 8'hC3, 1);
        e.ferr = 1'b1;
        chk_flags("R9 restart", e, 1'b0);
        clear_sts();

        // Random headers, R2 R3 R4 R5 R7 R8
        for (int t = 0; t < 24; t++) begin
            int         brk   = 8 + int'($urandom % 8);
            int         delim = 1 + int'($urandom % 2);
            int         gap   = int'($urandom % 2);
            logic [7:0] sy    = ($urandom % 4 == 0) ? 8'($urandom) : 8'h55;
            logic       sst   = ($urandom % 8 != 0);
            logic [7:0] id    = 8'($urandom);
            logic       ist   = ($urandom % 8 != 0);
            header(brk, delim, sy, sst, gap, id, ist);
            chk_flags("R5 random", predict(brk, sy, sst, id, ist), 1'b0);
            clear_sts();
            chk_flags("R8 random clear", '0, 1'b0);
        end

        finish_run();
    end
endmodule